// File: doc/BRIEF.md
# Two-Phase Interleaved Trailing-Edge PWM Generator

This block turns one stream of master timing ticks into two gate-drive pulse trains, phase A and phase B. The ticks come at twice the per-phase switching rate and are handed out in turn: one tick starts a period of A, the next starts a period of B. Because of this, B runs half a switching period behind A. Each phase measures the length of its own last period in clock cycles. At the start of every period it samples its duty word and turns it into an on-time. The output rises at the period start, which the tick fixes, and falls once the on-time has run out (trailing-edge modulation).

A duty clamp is shared by both phases. It is a fixed fraction of the period, so it follows the period when the tick spacing changes, for example under frequency dithering. Each phase has a peak-current cutoff of its own: an over-current flag seen while the output is high turns that phase off, and it stays off until that phase's next period. The other phase is not affected. A low enable turns both outputs off. Every period also leaves at least one cycle low, so neither output can stay high without a break.

The block is meant to sit between the digital current loops and the gate-driver pins of a two-phase boost converter.

Top module: `pwm2_interleave`

## Requirements
- R1: While reset is asserted both gate outputs are low. The first tick after reset starts phase A.
- R2: Ticks alternate between the phases: a tick that starts A is followed by a tick that starts B, and so on. The two outputs never rise in the same cycle.
- R3: A phase's period P is the number of clock cycles between its two most recent starts. Its on-time is floor(min(duty, DMAX) * P / 2^DUTY_W), where the duty word is an unsigned fraction of the period in units of 1/2^DUTY_W. The output goes high in the cycle after the start tick and stays high for exactly the on-time. In the first period after reset no P is known, so the output stays low.
- R4: Duty words above the clamp DMAX (default 243 of 256) are treated as DMAX. The clamp scales with the measured period.
- R5: The duty word is sampled only in the cycle of that phase's start tick. Changes at any other time have no effect on the current pulse.
- R6: An over-current flag of a phase forces that phase low in the next cycle. If the flag was seen while the output was high, the output stays low until that phase's next start, even after the flag clears.
- R7: The over-current flag of one phase has no effect on the other phase.
- R8: With enable low, both outputs are low in the next cycle. Raising enable again never starts a pulse in the middle of a period.
- R9: If a start tick arrives while that phase's output is still high (the period has shrunk), the output goes low for one cycle and then carries on with the new pulse. An output can rise only one cycle after its start tick or after such a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Master timing tick, one cycle wide, at twice the per-phase rate |
| enable_i | input | 1 | High to allow switching; low forces both outputs off |
| duty_a_i | input | DUTY_W | Phase A duty fraction |
| duty_b_i | input | DUTY_W | Phase B duty fraction |
| oc_a_i | input | 1 | Phase A over-current flag |
| oc_b_i | input | 1 | Phase B over-current flag |
| gate_a_o | output | 1 | Phase A gate drive |
| gate_b_o | output | 1 | Phase B gate drive |

## Verification
The assertions assume that ticks are one cycle wide and at least three cycles apart. Closer ticks could let a break-delayed rise of one phase coincide with the normal rise of the other. They also assume that a phase period stays below 2^CNT_W cycles, so the period counter never saturates. The stimulus spaces ticks from 8 to 23 cycles apart and includes periods that shrink suddenly. It raises the over-current flags in the middle of pulses, drops enable for a whole half period, and changes the duty words on every cycle, including duty words above the clamp.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    // Which phase the next master tick will start
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_sel_e;

    localparam int NUM_PHASES = 2;
endpackage

// File: rtl/pwm2_phase.sv
module pwm2_phase #(
    parameter int DUTY_W = 8,
    parameter int CNT_W  = 12,
    parameter int DMAX   = 243
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              enable_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              oc_i,
    output logic              gate_o
);
    localparam int                PROD_W  = DUTY_W + CNT_W;
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [DUTY_W-1:0] DMAX_W  = DUTY_W'(DMAX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;     // cycles since this phase's start
        logic [CNT_W-1:0] period;  // last measured period
        logic [CNT_W-1:0] on_len;  // on-time for the running period
        logic             seen;    // at least one start observed
        logic             trip;    // peak-current latch
        logic             brk;     // forced one-cycle break in progress
        logic             gate;
    } phase_st_t;

    phase_st_t st_d, st_q;

    logic [DUTY_W-1:0] duty_clamped;
    logic [CNT_W-1:0]  period_meas;
    logic [PROD_W-1:0] prod;
    logic              may_rise;

    always_comb begin
        st_d         = st_q;
        st_d.brk     = 1'b0;
        may_rise     = st_q.gate | st_q.brk;
        duty_clamped = (duty_i > DMAX_W) ? DMAX_W : duty_i;
        period_meas  = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        prod         = '0;

        if (start_i) begin
            st_d.cnt  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                st_d.period = period_meas;
            end
            prod        = PROD_W'(duty_clamped) * PROD_W'(st_d.period);
            st_d.on_len = CNT_W'(prod >> DUTY_W);
            st_d.trip   = 1'b0;
            st_d.brk    = st_q.gate;
            may_rise    = ~st_q.gate;
        end else begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.trip = st_q.trip | (oc_i & st_q.gate);
        end

        st_d.gate = enable_i & ~oc_i & ~st_d.trip & may_rise
                  & (st_d.cnt < st_d.on_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;
endmodule

// File: rtl/pwm2_interleave.sv
module pwm2_interleave
    import pwm2_pkg::*;
#(
    parameter int DUTY_W = 8,
    parameter int CNT_W  = 12,
    parameter int DMAX   = 243
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              enable_i,
    input  logic [DUTY_W-1:0] duty_a_i,
    input  logic [DUTY_W-1:0] duty_b_i,
    input  logic              oc_a_i,
    input  logic              oc_b_i,
    output logic              gate_a_o,
    output logic              gate_b_o
);
    phase_sel_e sel_d, sel_q;

    logic [NUM_PHASES-1:0] start;
    logic [NUM_PHASES-1:0] oc;
    logic [NUM_PHASES-1:0] gate;
    logic [DUTY_W-1:0]     duty [NUM_PHASES];

    always_comb begin
        sel_d    = tick_i ? phase_sel_e'(~sel_q) : sel_q;
        start[0] = tick_i & (sel_q == PH_A);
        start[1] = tick_i & (sel_q == PH_B);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= PH_A;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign duty[0] = duty_a_i;
    assign duty[1] = duty_b_i;
    assign oc      = {oc_b_i, oc_a_i};

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        pwm2_phase #(
            .DUTY_W (DUTY_W),
            .CNT_W  (CNT_W),
            .DMAX   (DMAX)
        ) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start[p]),
            .enable_i (enable_i),
            .duty_i   (duty[p]),
            .oc_i     (oc[p]),
            .gate_o   (gate[p])
        );
    end

    assign gate_a_o = gate[0];
    assign gate_b_o = gate[1];
endmodule

// File: rtl/pwm2_interleave_chk.sv
module pwm2_interleave_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic enable_i,
    input logic oc_a_i,
    input logic oc_b_i,
    input logic gate_a_o,
    input logic gate_b_o,
    input logic sel
);
    // R1: outputs held low during reset
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (!gate_a_o && !gate_b_o);
        end
    end

    // R2: the two phases never rise together
    assert_no_joint_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a_o) |-> !$rose(gate_b_o));

    // R3: a rise follows a start tick by one cycle, or by two after a break (R9)
    assert_rise_after_tick_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_a_o) |-> ($past(tick_i) || $past(tick_i, 2)));
    assert_rise_after_tick_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_b_o) |-> ($past(tick_i) || $past(tick_i, 2)));

    // R6: over-current cuts its own phase in the next cycle
    assert_oc_cut_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oc_a_i |=> !gate_a_o);
    assert_oc_cut_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oc_b_i |=> !gate_b_o);

    // R8: disable blanks both outputs
    assert_disable_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!gate_a_o && !gate_b_o));

    // R9: a start finding the output high forces one low cycle
    assert_min_off_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !sel && gate_a_o) |=> !gate_a_o);
    assert_min_off_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && sel && gate_b_o) |=> !gate_b_o);
endmodule

bind pwm2_interleave pwm2_interleave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .enable_i (enable_i),
    .oc_a_i   (oc_a_i),
    .oc_b_i   (oc_b_i),
    .gate_a_o (gate_a_o),
    .gate_b_o (gate_b_o),
    .sel      (sel_q)
);

// File: tb/pwm2_interleave_bench.sv
module pwm2_interleave_bench;
    localparam int DUTY_W = 8;
    localparam int CNT_W  = 12;
    localparam int DMAX   = 243;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, en = 1'b0, oca = 1'b0, ocb = 1'b0;
    logic [DUTY_W-1:0] da = '0, db = '0;
    logic ga, gb;

    always #2.5 clk = ~clk;

    pwm2_interleave #(.DUTY_W(DUTY_W), .CNT_W(CNT_W), .DMAX(DMAX)) u_pwm2_interleave (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .enable_i(en),
        .duty_a_i(da), .duty_b_i(db), .oc_a_i(oca), .oc_b_i(ocb),
        .gate_a_o(ga), .gate_b_o(gb)
    );

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    // ---------------- behavioural reference ----------------
    int cyc = 0;
    int nxt = 0;               // phase the next tick belongs to
    int seen [2], ts [2], per [2], onl [2], k [2];
    bit trip [2], brk [2], g [2];

    function automatic int clampd(int d);
        return (d > DMAX) ? DMAX : d;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc = 0; nxt = 0;
            for (int p = 0; p < 2; p++) begin
                seen[p] = 0; ts[p] = 0; per[p] = 0; onl[p] = 0; k[p] = 1 << 30;
                trip[p] = 0; brk[p] = 0; g[p] = 0;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                bit st, ov, allow, prev;
                int d;
                st = tick && (nxt == p);
                ov = (p == 0) ? oca : ocb;
                d  = (p == 0) ? int'(da) : int'(db);
                prev = g[p];
                if (st) begin
                    if (seen[p] != 0) per[p] = cyc - ts[p];
                    seen[p] = 1; ts[p] = cyc;
                    onl[p] = (clampd(d) * per[p]) / (1 << DUTY_W);
                    k[p] = 0; trip[p] = 0;
                    allow = !prev;
                    brk[p] = prev;
                end else begin
                    k[p] = k[p] + 1;
                    trip[p] = trip[p] | (ov & prev);
                    allow = prev | brk[p];
                    brk[p] = 0;
                end
                g[p] = en && !ov && !trip[p] && allow && (k[p] < onl[p]);
            end
            if (tick) nxt = 1 - nxt;
            cyc++;
        end
    end

    // ---------------- checking ----------------
    int hi_a = 0, hi_b = 0;

    task automatic check(string req, int act, int exp_v, string what);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp_v, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check(cur_req, int'(ga), int'(g[0]), "gate A");
        check(cur_req, int'(gb), int'(g[1]), "gate B");
        hi_a += int'(ga);
        hi_b += int'(gb);
    endtask

    int oc_a_at = -1, oc_b_at = -1, dis_h = -1;
    bit jitter = 0;

    task automatic run(int hp, int n);
        for (int h = 0; h < n; h++) begin
            for (int c = 0; c < hp; c++) begin
                step();
                tick = (c == 0);
                oca  = (c == oc_a_at);
                ocb  = (c == oc_b_at);
                en   = (h != dis_h);
                if (jitter) begin
                    da = DUTY_W'($urandom_range(0, 255));
                    db = DUTY_W'($urandom_range(0, 255));
                end
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (4) step();
        check("R1", int'(ga) + int'(gb), 0, "outputs in reset");
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;

        // R2 / R3: steady interleaved operation, A=1/2, B=1/4
        cur_req = "R3";
        da = 8'd128; db = 8'd64;
        run(20, 8);
        cur_req = "R2";
        hi_a = 0; hi_b = 0;
        run(20, 2);
        check("R3", hi_a, 20, "A high cycles per period");
        check("R2", hi_b, 10, "B high cycles per period");

        // R4: clamp
        cur_req = "R4";
        da = 8'd255; db = 8'd250;
        run(20, 4);
        hi_a = 0; hi_b = 0;
        run(20, 2);
        check("R4", hi_a, 37, "A clamped high cycles");
        check("R4", hi_b, 37, "B clamped high cycles");

        // R5: duty changed every cycle
        cur_req = "R5";
        jitter = 1;
        run(20, 8);
        jitter = 0;

        // R6 / R7: over-current on A only
        cur_req = "R6";
        da = 8'd200; db = 8'd200;
        run(20, 4);
        oc_a_at = 5;
        run(20, 4);
        cur_req = "R7";
        hi_a = 0; hi_b = 0;
        run(20, 2);
        check("R6", hi_a, 5, "A high cycles with trip");
        check("R7", hi_b, 31, "B high cycles beside A trip");
        oc_a_at = -1;
        oc_b_at = 3;
        run(20, 4);
        oc_b_at = -1;

        // R8: disable for one half period in the middle of pulses
        cur_req = "R8";
        run(20, 2);
        dis_h = 1;
        run(20, 4);
        dis_h = -1;
        run(20, 4);

        // R9: sudden period shrink while outputs are high
        cur_req = "R9";
        da = 8'd255; db = 8'd255;
        run(20, 4);
        run(8, 6);
        run(12, 6);

        // R4 under dithered tick spacing
        cur_req = "R4";
        da = 8'd240; db = 8'd100;
        for (int i = 0; i < 40; i++) run(16 + (i % 8), 1);

        done = 1;
        summary();
        $finish;
    end
endmodule